// File: doc/BRIEF.md
# SMBus Byte-Access Split-Region EEPROM Target

This block is an SMBus target that serves a 256-byte memory. It supports only two transactions. Write Byte sends a byte to an address. Read Byte uses a command phase, a repeated start and then a single data byte. The 8-bit command code is the byte address, and its MSB selects the region. The lower half (00h–7Fh) is a fixed information area. The upper half (80h–FFh) is a scratch area that the host can write.

Writes to the information area are acknowledged in every phase, but the data is thrown away. The scratch area is writable unless the active-high write-protect input is high. That input must be tied or weakly pulled low when unused, so that the area defaults to writable. After each accepted scratch write, the block stays busy for a parameterised number of clock cycles and does not acknowledge its own address during that time.

The block samples SCL and SDA through synchronizers. It does not drive the bus directly: it raises an open-drain enable that pulls SDA low.

Top module: `smb_eeprom_target`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o` = 0), and every scratch byte reads back as FFh.
- R2: A Read Byte to an address `a` below 80h returns the information byte `(a * 1Dh + 5Ah) mod 256`.
- R3: A start followed by a 7-bit address equal to `DEV_ADDR` is acknowledged by pulling SDA low in the ninth bit. Any other address is not acknowledged, and SDA stays released until the next start, including the ACK slot of any following byte.
- R4: A Write Byte to an address at or above 80h, with write-protect low, is acknowledged in all three ACK slots, and a later Read Byte of that address returns the written byte.
- R5: A Write Byte to an address below 80h is acknowledged in all three ACK slots. The memory stays unchanged, and no busy period starts.
- R6: A Write Byte to the scratch area while write-protect is high is acknowledged normally. The data is discarded, and no busy period starts.
- R7: After an accepted scratch write, the own address is not acknowledged for `BUSY_CYCLES` clock cycles. After that it is acknowledged again.
- R8: A start or stop seen in any state aborts the transaction and releases SDA. A Write Byte cut off before its data-byte ACK leaves memory unchanged.
- R9: SDA changes only while SCL is low and is held through the SCL high phase. Bytes are sent and received MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SMBus clock line as seen at the pad |
| sda_i | input | 1 | SMBus data line as seen at the pad (wired-AND value) |
| wp_i | input | 1 | Write protect for the scratch area, active high; tie or pull low when unused |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
Read Byte is tried at the bottom, middle and top of the information area, and at erased and written scratch addresses. Asymmetric data values show whether the address split, the fixed-content formula and MSB-first order are right.

Write Byte goes to both regions, with write-protect low and high. Each write is followed at once by a re-address. An acknowledged re-address and a refused one separate a real scratch commit from a write that was discarded.

A foreign address followed by another byte shows that the block stays off the bus until the next start. Write Bytes cut short by a stop, or by a repeated start inside the data byte, show that only a completed data ACK commits anything.

// File: rtl/smbe_pkg.sv
package smbe_pkg;

    localparam int BYTE_BITS  = 8;
    localparam int ADDR_BITS  = 8;
    localparam int HALF_BYTES = 2 ** (ADDR_BITS - 1);
    localparam int CNT_W      = $clog2(BYTE_BITS + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_CMD,
        ST_CACK,
        ST_WDATA,
        ST_DACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } state_t;

    typedef struct packed {
        logic                 en;
        logic [ADDR_BITS-1:0] addr;
        logic [BYTE_BITS-1:0] data;
    } wr_req_t;

    function automatic logic [BYTE_BITS-1:0] info_byte(input logic [ADDR_BITS-1:0] a);
        logic [BYTE_BITS-1:0] t;
        t = a * 8'h1D;
        return t + 8'h5A;
    endfunction

    function automatic logic in_scratch(input logic [ADDR_BITS-1:0] a);
        return a[ADDR_BITS-1];
    endfunction

endpackage

// File: rtl/smbe_sync.sv
module smbe_sync #(
    parameter int   W       = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    localparam int TOTAL = STAGES * W;

    logic [TOTAL-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= {TOTAL{RST_VAL}};
        end else begin
            sr_q <= {sr_q[TOTAL-W-1:0], d_i};
        end
    end

    assign q_o = sr_q[TOTAL-1 -: W];
endmodule

// File: rtl/smbe_mem.sv
module smbe_mem
    import smbe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  wr_req_t              wr_i,
    input  logic [ADDR_BITS-1:0] raddr_i,
    output logic [BYTE_BITS-1:0] rdata_o
);
    logic [BYTE_BITS-1:0] scratch_q [HALF_BYTES];

    genvar g;
    generate
        for (g = 0; g < HALF_BYTES; g++) begin : g_byte
            always_ff @(posedge clk) begin
                if (rst) begin
                    scratch_q[g] <= '1;
                end else if (wr_i.en && in_scratch(wr_i.addr)
                             && (wr_i.addr[ADDR_BITS-2:0] == (ADDR_BITS-1)'(g))) begin
                    scratch_q[g] <= wr_i.data;
                end
            end
        end
    endgenerate

    always_comb begin
        if (in_scratch(raddr_i)) begin
            rdata_o = scratch_q[raddr_i[ADDR_BITS-2:0]];
        end else begin
            rdata_o = info_byte(raddr_i);
        end
    end
endmodule

// File: rtl/smbe_busy.sv
module smbe_busy #(
    parameter int BUSY_CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic busy_o
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(BUSY_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/smbe_fsm.sv
module smbe_fsm
    import smbe_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_s_i,
    input  logic                 sda_s_i,
    input  logic                 wp_s_i,
    input  logic                 busy_i,
    input  logic [BYTE_BITS-1:0] rdata_i,
    output logic [ADDR_BITS-1:0] ptr_o,
    output wr_req_t              wr_o,
    output state_t               st_o,
    output logic                 oe_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);

    logic                 scl_d_q, sda_d_q;
    logic                 scl_rise, scl_fall, start_c, stop_c;
    state_t               st_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [BYTE_BITS-1:0] rx_q, tx_q, wdat_q;
    logic [ADDR_BITS-1:0] ptr_q;
    logic                 rd_q, oe_q, we_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d_q <= 1'b1;
            sda_d_q <= 1'b1;
        end else begin
            scl_d_q <= scl_s_i;
            sda_d_q <= sda_s_i;
        end
    end

    assign scl_rise = scl_s_i & ~scl_d_q;
    assign scl_fall = ~scl_s_i & scl_d_q;
    assign start_c  = scl_s_i & scl_d_q & sda_d_q & ~sda_s_i;
    assign stop_c   = scl_s_i & scl_d_q & ~sda_d_q & sda_s_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            rx_q   <= '0;
            tx_q   <= '0;
            wdat_q <= '0;
            ptr_q  <= '0;
            rd_q   <= 1'b0;
            oe_q   <= 1'b0;
            we_q   <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (start_c) begin
                st_q  <= ST_ADDR;
                cnt_q <= '0;
                oe_q  <= 1'b0;
            end else if (stop_c) begin
                st_q  <= ST_IDLE;
                cnt_q <= '0;
                oe_q  <= 1'b0;
            end else begin
                unique case (st_q)
                    ST_ADDR, ST_CMD, ST_WDATA: begin
                        if (scl_rise) begin
                            rx_q  <= {rx_q[BYTE_BITS-2:0], sda_s_i};
                            cnt_q <= cnt_q + 1'b1;
                        end else if (scl_fall && cnt_q == FULL) begin
                            cnt_q <= '0;
                            case (st_q)
                                ST_ADDR: begin
                                    if (rx_q[7:1] == DEV_ADDR && !busy_i) begin
                                        rd_q <= rx_q[0];
                                        st_q <= ST_AACK;
                                        oe_q <= 1'b1;
                                    end else begin
                                        st_q <= ST_IGNORE;
                                        oe_q <= 1'b0;
                                    end
                                end
                                ST_CMD: begin
                                    ptr_q <= rx_q;
                                    st_q  <= ST_CACK;
                                    oe_q  <= 1'b1;
                                end
                                default: begin
                                    wdat_q <= rx_q;
                                    st_q   <= ST_DACK;
                                    oe_q   <= 1'b1;
                                end
                            endcase
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            cnt_q <= '0;
                            if (rd_q) begin
                                tx_q <= rdata_i;
                                oe_q <= ~rdata_i[BYTE_BITS-1];
                                st_q <= ST_RDATA;
                            end else begin
                                oe_q <= 1'b0;
                                st_q <= ST_CMD;
                            end
                        end
                    end
                    ST_CACK: begin
                        if (scl_fall) begin
                            oe_q <= 1'b0;
                            st_q <= ST_WDATA;
                        end
                    end
                    ST_DACK: begin
                        if (scl_fall) begin
                            oe_q <= 1'b0;
                            st_q <= ST_IGNORE;
                            we_q <= in_scratch(ptr_q) & ~wp_s_i;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            cnt_q <= cnt_q + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt_q == FULL) begin
                                cnt_q <= '0;
                                oe_q  <= 1'b0;
                                st_q  <= ST_RACK;
                            end else begin
                                tx_q <= {tx_q[BYTE_BITS-2:0], 1'b0};
                                oe_q <= ~tx_q[BYTE_BITS-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_fall) begin
                            st_q <= ST_IGNORE;
                        end
                    end
                    default: begin
                        oe_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign ptr_o   = ptr_q;
    assign wr_o.en   = we_q;
    assign wr_o.addr = ptr_q;
    assign wr_o.data = wdat_q;
    assign st_o    = st_q;
    assign oe_o    = oe_q;
endmodule

// File: rtl/smb_eeprom_target.sv
module smb_eeprom_target
    import smbe_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         BUSY_CYCLES = 1250000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe_o
);
    logic [1:0]           bus_s;
    logic                 scl_s, sda_s, wp_s;
    logic                 busy_w;
    logic [ADDR_BITS-1:0] ptr_w;
    logic [BYTE_BITS-1:0] rdata_w;
    wr_req_t              wr_w;
    state_t               st_w;
    logic                 we_w;
    logic [ADDR_BITS-1:0] waddr_w;

    smbe_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) bus_sync_i (
        .clk(clk), .rst(rst), .d_i({scl_i, sda_i}), .q_o(bus_s)
    );

    smbe_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) wp_sync_i (
        .clk(clk), .rst(rst), .d_i(wp_i), .q_o(wp_s)
    );

    assign scl_s = bus_s[1];
    assign sda_s = bus_s[0];

    smbe_fsm #(.DEV_ADDR(DEV_ADDR)) fsm_i (
        .clk(clk), .rst(rst),
        .scl_s_i(scl_s), .sda_s_i(sda_s), .wp_s_i(wp_s),
        .busy_i(busy_w), .rdata_i(rdata_w),
        .ptr_o(ptr_w), .wr_o(wr_w), .st_o(st_w), .oe_o(sda_oe_o)
    );

    smbe_mem mem_i (
        .clk(clk), .rst(rst), .wr_i(wr_w), .raddr_i(ptr_w), .rdata_o(rdata_w)
    );

    smbe_busy #(.BUSY_CYCLES(BUSY_CYCLES)) busy_i (
        .clk(clk), .rst(rst), .load_i(wr_w.en), .busy_o(busy_w)
    );

    assign we_w    = wr_w.en;
    assign waddr_w = wr_w.addr;
endmodule

// File: rtl/smbe_target_chk.sv
module smbe_target_chk
    import smbe_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 scl_s,
    input logic                 wp_s,
    input logic                 sda_oe_o,
    input state_t               st_w,
    input logic                 busy_w,
    input logic                 we_w,
    input logic [ADDR_BITS-1:0] waddr_w
);
    AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe_o)); // R9

    AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (st_w == ST_AACK) |-> !busy_w); // R7

    AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        we_w |=> busy_w); // R7

    AST_WRITE_SCRATCH_ONLY: assert property (@(posedge clk) disable iff (rst)
        we_w |-> waddr_w[ADDR_BITS-1]); // R5

    AST_WRITE_WP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        we_w |-> !$past(wp_s)); // R6

    AST_IGNORE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (st_w == ST_IGNORE) |-> !sda_oe_o); // R3

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (st_w == ST_IDLE) |-> !sda_oe_o); // R8
endmodule

bind smb_eeprom_target smbe_target_chk chk_i (
    .clk(clk), .rst(rst), .scl_s(scl_s), .wp_s(wp_s), .sda_oe_o(sda_oe_o),
    .st_w(st_w), .busy_w(busy_w), .we_w(we_w), .waddr_w(waddr_w)
);

// File: tb/smb_eeprom_target_tb.sv
module smb_eeprom_target_tb_top;
    localparam logic [6:0] DEV  = 7'h50;
    localparam int         BUSY = 3000;
    localparam int         Q    = 16;

    typedef struct {
        logic [7:0] v;
        string      req;
        string      what;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    item_t      exp_q[$];
    logic [7:0] obs_q[$];

    always #4 clk = ~clk;

    assign sda_line = sda_h & ~sda_oe;

    smb_eeprom_target #(.DEV_ADDR(DEV), .BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_h), .sda_i(sda_line),
        .wp_i(wp), .sda_oe_o(sda_oe)
    );

    function automatic logic [7:0] info(input logic [7:0] a);
        logic [7:0] t;
        t = a * 8'h1D;
        return t + 8'h5A;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_item(input logic [7:0] v, input string req, input string what);
        item_t it;
        it.v = v; it.req = req; it.what = what;
        exp_q.push_back(it);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                item_t e;
                logic [7:0] o;
                e = exp_q.pop_front();
                o = obs_q.pop_front();
                checks++;
                if (o !== e.v) begin
                    errors++;
                    $display("FAIL %s %s actual=%h expected=%h", e.req, e.what, o, e.v);
                end
            end
        end
    end

    task automatic bus_start();
        sda_h = 1'b1; wait_clk(Q);
        scl_h = 1'b1; wait_clk(Q);
        sda_h = 1'b0; wait_clk(Q);
        scl_h = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; wait_clk(Q);
        scl_h = 1'b1; wait_clk(Q);
        sda_h = 1'b1; wait_clk(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_h = b; wait_clk(Q);
        scl_h = 1'b1; wait_clk(2 * Q);
        scl_h = 1'b0; wait_clk(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_h = 1'b1; wait_clk(Q);
        scl_h = 1'b1; wait_clk(Q);
        b = sda_line; wait_clk(Q);
        scl_h = 1'b0; wait_clk(Q);
    endtask

    task automatic put_byte(input logic [7:0] d);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(a);
        obs_q.push_back({7'd0, a});
    endtask

    task automatic get_byte(input logic host_ack);
        logic [7:0] d;
        for (int i = 7; i >= 0; i--) get_bit(d[i]);
        put_bit(host_ack);
        obs_q.push_back(d);
    endtask

    task automatic read_txn(input logic [7:0] a, input logic [7:0] exp_d, input string req);
        expect_item(8'h00, req, "addr-W ack");
        expect_item(8'h00, req, "cmd ack");
        expect_item(8'h00, req, "addr-R ack");
        expect_item(exp_d, req, "read data");
        bus_start();
        put_byte({DEV, 1'b0});
        put_byte(a);
        bus_start();
        put_byte({DEV, 1'b1});
        get_byte(1'b1);
        bus_stop();
    endtask

    task automatic write_txn(input logic [7:0] a, input logic [7:0] d, input string req);
        expect_item(8'h00, req, "addr-W ack");
        expect_item(8'h00, req, "cmd ack");
        expect_item(8'h00, req, "data ack");
        bus_start();
        put_byte({DEV, 1'b0});
        put_byte(a);
        put_byte(d);
        bus_stop();
    endtask

    task automatic probe_addr(input logic exp_nack, input string req);
        expect_item({7'd0, exp_nack}, req, "address probe ack");
        bus_start();
        put_byte({DEV, 1'b0});
        bus_stop();
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all) actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);
        // R1: released after reset, scratch erased
        checks++;
        if (sda_oe !== 1'b0) begin
            errors++;
            $display("FAIL R1 sda_oe after reset actual=%b expected=0", sda_oe);
        end
        read_txn(8'hA0, 8'hFF, "R1");

        // R2 + R9: information area, MSB-first data
        read_txn(8'h00, info(8'h00), "R2");
        read_txn(8'h05, info(8'h05), "R2");
        read_txn(8'h7F, info(8'h7F), "R9");

        // R4 + R7: scratch write, busy refuses own address, then recovers
        write_txn(8'h80, 8'h3C, "R4");
        probe_addr(1'b1, "R7");
        wait_clk(BUSY + 200);
        read_txn(8'h80, 8'h3C, "R4");

        // R5: info write acked, discarded, no busy
        write_txn(8'h10, 8'h00, "R5");
        read_txn(8'h10, info(8'h10), "R5");

        // R6: write protect
        wp = 1'b1;
        wait_clk(10);
        write_txn(8'hC4, 8'h77, "R6");
        read_txn(8'hC4, 8'hFF, "R6");
        wp = 1'b0;
        wait_clk(10);

        // R3: foreign address ignored until next start
        expect_item(8'h01, "R3", "foreign address ack");
        expect_item(8'h01, "R3", "byte after foreign address");
        bus_start();
        put_byte({7'h23, 1'b0});
        put_byte(8'h80);
        bus_stop();
        read_txn(8'h80, 8'h3C, "R3");

        // R8: stop inside data byte
        expect_item(8'h00, "R8", "addr-W ack");
        expect_item(8'h00, "R8", "cmd ack");
        bus_start();
        put_byte({DEV, 1'b0});
        put_byte(8'h90);
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        bus_stop();
        probe_addr(1'b0, "R8");
        read_txn(8'h90, 8'hFF, "R8");

        // R8: repeated start inside data byte turns into a read
        expect_item(8'h00, "R8", "addr-W ack");
        expect_item(8'h00, "R8", "cmd ack");
        expect_item(8'h00, "R8", "addr-R ack");
        expect_item(8'hFF, "R8", "read after aborted write");
        bus_start();
        put_byte({DEV, 1'b0});
        put_byte(8'h91);
        for (int i = 0; i < 3; i++) put_bit(1'b0);
        bus_start();
        put_byte({DEV, 1'b1});
        get_byte(1'b1);
        bus_stop();

        // R4 + R9: top scratch byte, asymmetric pattern
        write_txn(8'hFF, 8'hA5, "R4");
        wait_clk(BUSY + 200);
        read_txn(8'hFF, 8'hA5, "R9");
        write_txn(8'h81, 8'h01, "R4");
        probe_addr(1'b1, "R7");
        wait_clk(BUSY + 200);
        read_txn(8'h81, 8'h01, "R4");

        wait_clk(20);
        done = 1'b1;
        checks += 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule